// File: doc/BRIEF.md
# Key-Guarded Register Write Controller

This block decides which writes on a byte-wide register bus may reach a small bank of protected registers. Software must first feed a fixed four-byte pass sequence into a dedicated key index; only then are writes to the protected indices turned into per-register write enables. A separate exit byte closes the guard again, and reading the key index tells software whether the guard is currently open.

Two independent clear sources can force the guard shut. One is a watchdog that software arms through its own index with an enable and a 7-bit count; it counts down on a prescaled timebase, emits a one-cycle clear pulse when it runs out and then disarms itself. The other is an active-low board pin, synchronised internally, that only has an effect once software has set the enable bit in the pin-control index. The clear pulse is exported so that the neighbouring register bank can reset its contents.

Top module: `regguard_top`

## Requirements
- R1: Writing 0x32, 0x5D, 0x42 and 0xAC to the key index (default 0x20) on four consecutive key writes sets `unlocked` to 1 on the clock edge that captures 0xAC; `key_rdata` then reads 0xFF.
- R2: After reset the guard is closed: `unlocked` is 0, `key_rdata` is 0x00, `clr_pulse` is 0 and no write enable is active.
- R3: A key byte that does not match the next expected byte restarts the matching from the beginning; if that byte is 0x32 it is counted as the first byte of a new attempt.
- R4: Writing 0x35 to the key index closes the guard on the next edge; while the guard is open, any other key byte leaves it open.
- R5: `wr_grant[i]` is 1 exactly while a write to index i (0 to NUM_PROT-1) is presented and the guard is open; while closed, writes to protected indices, to the watchdog index (0x21) and to the pin-control index (0x22) are ignored.
- R6: The watchdog index holds the enable in bit 7 and the count in bits 6:0; an accepted write loads both and restarts the prescaler.
- R7: While enabled, the count drops by one every PRESC_DIV ticks (default 4); on the prescaled step that finds it at zero the block raises `clr_pulse` for one cycle and clears its own enable, so with count N the pulse follows the (N+1)·PRESC_DIV-th tick and no further pulse comes.
- R8: One edge after `clr_pulse` is high the guard is closed and any partial key match is discarded.
- R9: Bit 0 of the pin-control index enables the external clear pin and resets to 0; with it at 0 a low pin has no effect.
- R10: With the pin enabled, `clr_pulse` rises on the third clock edge after the pin goes low, stays high while the pin remains low, and closes the guard one edge later.
- R11: In a cycle where `clr_pulse` is high, every write enable is 0 and a key byte written in that cycle cannot open the guard.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | IDX_W | Register index of the write |
| wr_data | input | 8 | Write data byte |
| tick | input | 1 | Timebase tick for the watchdog prescaler |
| ext_clr_n | input | 1 | Asynchronous active-low external clear pin |
| wr_grant | output | NUM_PROT | Per-register write enables for the protected bank |
| unlocked | output | 1 | Guard open status |
| key_rdata | output | 8 | Key index readback (0xFF open, 0x00 closed) |
| clr_pulse | output | 1 | Clear request to the protected bank |

## Verification
The watchdog expiry and a register-bus write can land in the same cycle: the clear pulse is registered, so the cycle in which it is visible is also a cycle in which software may present the last unlock byte or a protected write. The bench arms the watchdog with count zero, pre-loads three of the four key bytes, then drives the final 0xAC or a protected-index write exactly in the clear cycle. It judges the result by seeing the write enable stay low in that cycle and the guard read closed on the following one.

// File: rtl/regguard_pkg.sv
package regguard_pkg;

  localparam int          SEQ_LEN     = 4;
  localparam int          WD_CNT_W    = 7;
  localparam int          WD_EN_BIT   = 7;
  localparam logic [7:0]  KEY_EXIT    = 8'h35;
  localparam logic [7:0]  KEY_RD_OPEN = 8'hFF;
  localparam logic [7:0]  KEY_RD_SHUT = 8'h00;

  // Expected byte at each position of the pass sequence.
  function automatic logic [7:0] key_byte(input logic [1:0] pos);
    case (pos)
      2'd0:    key_byte = 8'h32;
      2'd1:    key_byte = 8'h5D;
      2'd2:    key_byte = 8'h42;
      default: key_byte = 8'hAC;
    endcase
  endfunction

endpackage

// File: rtl/regguard_keyfsm.sv
module regguard_keyfsm
  import regguard_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       key_wr,
  input  logic [7:0] key_data,
  output logic       unlocked
);

  logic [1:0] stage_q, stage_d;
  logic       open_q,  open_d;

  always_comb begin
    stage_d = stage_q;
    open_d  = open_q;
    if (clr) begin
      stage_d = 2'd0;
      open_d  = 1'b0;
    end else if (key_wr) begin
      if (key_data == KEY_EXIT) begin
        stage_d = 2'd0;
        open_d  = 1'b0;
      end else if (!open_q) begin
        if (key_data == key_byte(stage_q)) begin
          if (stage_q == 2'(SEQ_LEN - 1)) begin
            stage_d = 2'd0;
            open_d  = 1'b1;
          end else begin
            stage_d = stage_q + 2'd1;
          end
        end else if (key_data == key_byte(2'd0)) begin
          stage_d = 2'd1;
        end else begin
          stage_d = 2'd0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'd0;
      open_q  <= 1'b0;
    end else begin
      stage_q <= stage_d;
      open_q  <= open_d;
    end
  end

  assign unlocked = open_q;

endmodule

// File: rtl/regguard_wdog.sv
module regguard_wdog
  import regguard_pkg::*;
#(
  parameter  int PRESC_DIV = 4,
  localparam int PW        = (PRESC_DIV > 1) ? $clog2(PRESC_DIV) : 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       load,
  input  logic [7:0] load_data,
  input  logic       tick,
  output logic       expire
);

  localparam logic [PW-1:0] PLAST = PW'(PRESC_DIV - 1);

  logic                en_q,   en_d;
  logic [WD_CNT_W-1:0] cnt_q,  cnt_d;
  logic [PW-1:0]       pre_q,  pre_d;

  always_comb begin
    en_d   = en_q;
    cnt_d  = cnt_q;
    pre_d  = pre_q;
    expire = 1'b0;
    if (clr) begin
      en_d = 1'b0;
    end else if (load) begin
      en_d  = load_data[WD_EN_BIT];
      cnt_d = load_data[WD_CNT_W-1:0];
      pre_d = '0;
    end else if (en_q && tick) begin
      if (pre_q == PLAST) begin
        pre_d = '0;
        if (cnt_q == '0) begin
          en_d   = 1'b0;
          expire = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end else begin
        pre_d = pre_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      cnt_q <= '0;
      pre_q <= '0;
    end else begin
      en_q  <= en_d;
      cnt_q <= cnt_d;
      pre_q <= pre_d;
    end
  end

endmodule

// File: rtl/regguard_pinsync.sv
module regguard_pinsync (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  input  logic enable,
  output logic hit
);

  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
    end else begin
      s1_q <= pin_n;
      s2_q <= s1_q;
    end
  end

  assign hit = enable & ~s2_q;

endmodule

// File: rtl/regguard_top.sv
module regguard_top
  import regguard_pkg::*;
#(
  parameter int               IDX_W     = 8,
  parameter int               NUM_PROT  = 8,
  parameter logic [IDX_W-1:0] KEY_IDX   = 'h20,
  parameter logic [IDX_W-1:0] WDT_IDX   = 'h21,
  parameter logic [IDX_W-1:0] PIN_IDX   = 'h22,
  parameter int               PRESC_DIV = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    wr_idx,
  input  logic [7:0]          wr_data,
  input  logic                tick,
  input  logic                ext_clr_n,
  output logic [NUM_PROT-1:0] wr_grant,
  output logic                unlocked,
  output logic [7:0]          key_rdata,
  output logic                clr_pulse
);

  logic key_wr, pass, wdt_load, pin_load;
  logic wd_expire, pin_hit;
  logic clr_q, clr_d;
  logic pin_en_q, pin_en_d;

  assign key_wr   = wr_en && (wr_idx == KEY_IDX);
  assign pass     = wr_en && unlocked && !clr_q;
  assign wdt_load = pass && (wr_idx == WDT_IDX);
  assign pin_load = pass && (wr_idx == PIN_IDX);

  generate
    for (genvar i = 0; i < NUM_PROT; i++) begin : g_grant
      assign wr_grant[i] = pass && (wr_idx == IDX_W'(i));
    end
  endgenerate

  regguard_keyfsm u_key (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr_q),
    .key_wr   (key_wr),
    .key_data (wr_data),
    .unlocked (unlocked)
  );

  regguard_wdog #(.PRESC_DIV(PRESC_DIV)) u_wdog (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr_q),
    .load      (wdt_load),
    .load_data (wr_data),
    .tick      (tick),
    .expire    (wd_expire)
  );

  regguard_pinsync u_pin (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_n  (ext_clr_n),
    .enable (pin_en_q),
    .hit    (pin_hit)
  );

  always_comb begin
    pin_en_d = pin_en_q;
    if (pin_load) pin_en_d = wr_data[0];
    clr_d = wd_expire | pin_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_en_q <= 1'b0;
      clr_q    <= 1'b0;
    end else begin
      pin_en_q <= pin_en_d;
      clr_q    <= clr_d;
    end
  end

  assign clr_pulse = clr_q;
  assign key_rdata = unlocked ? KEY_RD_OPEN : KEY_RD_SHUT;

endmodule

// File: rtl/regguard_chk.sv
module regguard_chk #(
  parameter int               IDX_W    = 8,
  parameter int               NUM_PROT = 8,
  parameter logic [IDX_W-1:0] KEY_IDX  = 'h20
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wr_en,
  input logic [IDX_W-1:0]    wr_idx,
  input logic [7:0]          wr_data,
  input logic [NUM_PROT-1:0] wr_grant,
  input logic                unlocked,
  input logic                clr_pulse
);

  assert_open_needs_final_byte_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> ($past(wr_en) && $past(wr_idx) == KEY_IDX && $past(wr_data) == 8'hAC));

  assert_exit_byte_closes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == KEY_IDX && wr_data == 8'h35) |=> !unlocked);

  assert_closed_no_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |-> (wr_grant == '0));

  assert_single_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_grant));

  assert_clear_closes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pulse |=> !unlocked);

  assert_clear_blocks_grant_R11: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pulse |-> (wr_grant == '0));

endmodule

bind regguard_top regguard_chk #(
  .IDX_W   (IDX_W),
  .NUM_PROT(NUM_PROT),
  .KEY_IDX (KEY_IDX)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .wr_idx   (wr_idx),
  .wr_data  (wr_data),
  .wr_grant (wr_grant),
  .unlocked (unlocked),
  .clr_pulse(clr_pulse)
);

// File: tb/tb_regguard_top.sv
module tb_regguard_top;

  localparam int         CLK_PERIOD = 10;
  localparam logic [7:0] KEY = 8'h20;
  localparam logic [7:0] WDT = 8'h21;
  localparam logic [7:0] PIN = 8'h22;
  localparam int         NV  = 17;
  // {key byte, expected unlocked after the write}
  localparam logic [8:0] VEC [NV] = '{
    {8'h32,1'b0}, {8'h5D,1'b0}, {8'h42,1'b0}, {8'hAC,1'b1},
    {8'h11,1'b1}, {8'h35,1'b0},
    {8'h32,1'b0}, {8'h5D,1'b0}, {8'h00,1'b0}, {8'h42,1'b0}, {8'hAC,1'b0},
    {8'h32,1'b0}, {8'h5D,1'b0}, {8'h32,1'b0}, {8'h5D,1'b0}, {8'h42,1'b0},
    {8'hAC,1'b1}
  };

  logic       clk = 1'b0;
  logic       rst_n, wr_en, tick, ext_clr_n;
  logic [7:0] wr_idx, wr_data, wr_grant, key_rdata;
  logic       unlocked, clr_pulse;
  int         checks = 0, fails = 0, pulses = 0, p0;

  regguard_top dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .tick(tick), .ext_clr_n(ext_clr_n), .wr_grant(wr_grant), .unlocked(unlocked),
    .key_rdata(key_rdata), .clr_pulse(clr_pulse)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) if (rst_n && clr_pulse) pulses++;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  task automatic wr(input logic [7:0] idx, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_idx = idx; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic grant_chk(input string tag, input logic [7:0] idx, input logic [7:0] exp);
    @(negedge clk); wr_en = 1'b1; wr_idx = idx; wr_data = 8'h5A;
    #1 chk(tag, wr_grant, exp);
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic open_guard();
    wr(KEY, 8'h32); wr(KEY, 8'h5D); wr(KEY, 8'h42); wr(KEY, 8'hAC);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_idx = '0; wr_data = '0; tick = 1'b0; ext_clr_n = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2 unlocked after reset", unlocked, 0);
    chk("R2 key_rdata after reset", key_rdata, 8'h00);
    chk("R2 clr_pulse after reset", clr_pulse, 0);
    chk("R2 grants after reset", wr_grant, 0);

    // closed guard: protected and watchdog writes ignored
    grant_chk("R5 closed protected write", 8'd3, 8'h00);
    p0 = pulses;
    wr(WDT, 8'h80); ticks(8);
    chk("R5 closed watchdog write ignored", pulses - p0, 0);

    for (int v = 0; v < NV; v++) begin
      wr(KEY, VEC[v][8:1]);
      chk($sformatf("R1/R3/R4 key vector %0d unlocked", v), unlocked, VEC[v][0]);
      chk($sformatf("R1/R4 key vector %0d readback", v), key_rdata, VEC[v][0] ? 8'hFF : 8'h00);
    end

    // pin disabled by default
    p0 = pulses;
    @(negedge clk); ext_clr_n = 1'b0;
    repeat (6) @(negedge clk);
    chk("R9 disabled pin keeps guard open", unlocked, 1);
    chk("R9 disabled pin gives no pulse", pulses - p0, 0);
    ext_clr_n = 1'b1;
    repeat (3) @(negedge clk);

    grant_chk("R5 open write idx5", 8'd5, 8'h20);
    grant_chk("R5 open write idx7", 8'd7, 8'h80);
    grant_chk("R5 open write out of range", 8'h30, 8'h00);

    // watchdog count 2: pulse follows the 12th tick
    p0 = pulses;
    wr(WDT, 8'h82);
    ticks(11);
    chk("R7 no pulse before expiry", pulses - p0, 0);
    chk("R7 guard open before expiry", unlocked, 1);
    ticks(1);
    chk("R7 pulse after 12th tick", clr_pulse, 1);
    chk("R8 guard still open in pulse cycle", unlocked, 1);
    @(negedge clk);
    chk("R7 pulse lasts one cycle", clr_pulse, 0);
    chk("R8 guard closed after pulse", unlocked, 0);
    ticks(16);
    chk("R7 watchdog disarmed itself", pulses - p0, 1);

    // reload restarts count and prescaler
    open_guard();
    p0 = pulses;
    wr(WDT, 8'h81); ticks(6);
    wr(WDT, 8'h81); ticks(7);
    chk("R6 reload delays expiry", pulses - p0, 0);
    ticks(1);
    chk("R6 pulse 8 ticks after reload", clr_pulse, 1);
    @(negedge clk);
    chk("R8 closed after reload expiry", unlocked, 0);

    // final key byte lands in the clear cycle
    open_guard();
    wr(WDT, 8'h80);
    wr(KEY, 8'h35);
    wr(KEY, 8'h32); wr(KEY, 8'h5D); wr(KEY, 8'h42);
    ticks(3);
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    chk("R11 pulse cycle reached", clr_pulse, 1);
    wr_en = 1'b1; wr_idx = KEY; wr_data = 8'hAC;
    @(negedge clk); wr_en = 1'b0;
    chk("R11 key byte in clear cycle cannot open", unlocked, 0);

    // protected write in the clear cycle
    open_guard();
    wr(WDT, 8'h80);
    ticks(3);
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    chk("R11 pulse cycle reached again", clr_pulse, 1);
    wr_en = 1'b1; wr_idx = 8'd2; wr_data = 8'h11;
    #1 chk("R11 grant blocked in clear cycle", wr_grant, 8'h00);
    @(negedge clk); wr_en = 1'b0;
    chk("R8 closed after second expiry", unlocked, 0);

    // enabled external pin
    open_guard();
    wr(PIN, 8'h01);
    @(negedge clk); ext_clr_n = 1'b0;
    @(negedge clk); chk("R10 no pulse after 1 edge", clr_pulse, 0);
    @(negedge clk); chk("R10 no pulse after 2 edges", clr_pulse, 0);
    @(negedge clk); chk("R10 pulse after 3 edges", clr_pulse, 1);
    chk("R10 guard open in first pin cycle", unlocked, 1);
    @(negedge clk); chk("R10 guard closed by pin", unlocked, 0);
    repeat (3) @(negedge clk);
    chk("R10 clear held while pin low", clr_pulse, 1);
    ext_clr_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10 clear drops after release", clr_pulse, 0);
    open_guard();
    chk("R9 guard reopens after release", unlocked, 1);

    finish_run();
  end

endmodule